// File: doc/BRIEF.md
# ATM Cell Header Error Checker

The block checks the header error control byte of each ATM cell arriving on a byte-wide stream. A start-of-cell marker comes with byte 0 of each 53-byte cell. The block gathers the four header bytes. When the fifth byte (the received check byte) arrives, it computes a syndrome against the expected value. The expected value is the CRC-8 of the header, using x^8+x^2+x+1, XORed with 0x55. A non-zero syndrome is matched against all 40 single-bit error patterns of the header and check byte.

A two-bit policy, captured with each start-of-cell, selects what happens to an errored cell. The cell may pass untouched, have a single-bit error repaired, be marked for discard, or be repaired when possible and marked otherwise. All 53 bytes leave the block after a fixed delay, with repaired bytes in place of the received ones. A discard mark, an idle-cell mark and an unassigned-cell mark are given with the last byte of the cell. Downstream logic uses these marks to drop or count cells.

Top module: `hec_checker`

## Requirements
- R1: A cell whose check byte equals CRC-8 (x^8+x^2+x+1, zero initial value, header bit 31 first) of the 32 header bits XORed with 0x55 leaves unchanged and without a discard mark, in every policy.
- R2: With policy 2'b00, every cell leaves unmodified and is never marked for discard, whatever its check byte.
- R3: With policy 2'b01, a single flipped bit anywhere in the 40 bits of header and check byte is restored in the output bytes, and the cell is not marked for discard.
- R4: With policy 2'b01, a cell with more than one wrong bit, whose syndrome matches no single-bit pattern, leaves unmodified and without a discard mark.
- R5: With policy 2'b10, no byte is ever altered, and any cell with a non-zero syndrome is marked for discard.
- R6: With policy 2'b11, a single-bit error is restored without a discard mark, and a non-zero syndrome that matches no single-bit pattern marks the cell for discard.
- R7: The idle mark is raised for a cell whose header, after any repair, is 32'h0000_0001.
- R8: The unassigned mark is raised for a cell whose repaired header has bits 31:4 and bit 0 all zero; bits 3:1 are don't-care. The idle and unassigned marks are never raised together.
- R9: The policy is sampled with the start-of-cell byte. Changing the policy input later in the same cell has no effect on that cell.
- R10: Every accepted byte appears at the output exactly 6 clock cycles after the cycle in which it is presented. The output start marker is on byte 0 and the end marker on byte 52. Payload bytes pass unchanged, and gaps in the valid input after the header are allowed. After reset the output valid is low.
- R11: The discard, idle and unassigned marks are high only in the cycle that carries the end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Error policy, sampled with start-of-cell |
| in_valid_i | input | 1 | Input byte valid |
| in_sop_i | input | 1 | Input byte is byte 0 of a cell |
| in_data_i | input | 8 | Input byte |
| out_valid_o | output | 1 | Output byte valid |
| out_sop_o | output | 1 | Output byte is byte 0 of a cell |
| out_eop_o | output | 1 | Output byte is byte 52 of a cell |
| out_data_o | output | 8 | Output byte, header repaired when enabled |
| discard_o | output | 1 | Cell marked for discard, with end marker |
| idle_o | output | 1 | Cell is idle, with end marker |
| unassigned_o | output | 1 | Cell is unassigned, with end marker |

## Verification
The assertions assume that the source delivers the five header bytes on consecutive cycles, starts every cell with a start-of-cell marker, and sends exactly 53 bytes per cell. The assertions also assume that input valid is held low throughout reset. The bench drives only whole cells with contiguous headers. It inserts random idle cycles only after the check byte and keeps valid low during reset, so the fixed-latency and marker checks stay within those limits.

// File: rtl/hec_pkg.sv
package hec_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 4;
  localparam int HDR_BITS   = HDR_BYTES * 8;
  localparam int CW_BITS    = HDR_BITS + 8;
  localparam int POS_W      = $clog2(CELL_BYTES);
  localparam int ALIGN      = HDR_BYTES + 1;  // delay stages so the fix mask is ready for byte 0
  localparam logic [POS_W-1:0] HEC_POS  = POS_W'(HDR_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES - 1);

  typedef enum logic [1:0] {
    POL_PASS    = 2'b00,
    POL_FIX     = 2'b01,
    POL_DROP    = 2'b10,
    POL_FIXDROP = 2'b11
  } hec_pol_e;

  typedef struct packed {
    logic             vld;
    logic [POS_W-1:0] pos;
    logic [7:0]       dat;
  } beat_t;

  // bit-serial CRC-8, poly x^8+x^2+x+1, zero init, msb first
  function automatic logic [7:0] crc8_hdr(input logic [HDR_BITS-1:0] h);
    logic [7:0] c;
    logic       fb;
    c = '0;
    for (int i = HDR_BITS - 1; i >= 0; i--) begin
      fb = c[7] ^ h[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction
endpackage

// File: rtl/hec_syndrome.sv
module hec_syndrome
  import hec_pkg::*;
#(
  parameter logic [7:0] COSET = 8'h55
) (
  input  logic [HDR_BITS-1:0] hdr_i,
  input  logic [7:0]          hec_i,
  output logic [CW_BITS-1:0]  flip_o,
  output logic                err_o,
  output logic                single_o
);
  logic [7:0]         syn;
  logic [CW_BITS-1:0] hit;

  assign syn = crc8_hdr(hdr_i) ^ COSET ^ hec_i;

  // one comparator per codeword bit; header patterns are the linear CRC of a unit vector
  for (genvar k = 0; k < CW_BITS; k++) begin : g_pat
    if (k < 8) begin : g_chk
      assign hit[k] = (syn == 8'(1 << k));
    end else begin : g_hdr
      localparam logic [7:0] PAT = crc8_hdr(HDR_BITS'(1) << (k - 8));
      assign hit[k] = (syn == PAT);
    end
  end

  assign flip_o   = hit;
  assign err_o    = |syn;
  assign single_o = |hit;
endmodule

// File: rtl/hec_delay.sv
module hec_delay
  import hec_pkg::*;
#(
  parameter int DEPTH = ALIGN
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  beat_t in_i,
  output beat_t out_o
);
  beat_t stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= '0;
        else         stg[i] <= in_i;
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= '0;
        else         stg[i] <= stg[i-1];
    end
  end

  assign out_o = stg[DEPTH-1];
endmodule

// File: rtl/hec_checker.sv
module hec_checker
  import hec_pkg::*;
#(
  parameter logic [7:0] COSET = 8'h55
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       in_valid_i,
  input  logic       in_sop_i,
  input  logic [7:0] in_data_i,
  output logic       out_valid_o,
  output logic       out_sop_o,
  output logic       out_eop_o,
  output logic [7:0] out_data_o,
  output logic       discard_o,
  output logic       idle_o,
  output logic       unassigned_o
);
  localparam logic [HDR_BITS-1:0] IDLE_HDR = HDR_BITS'(1);
  localparam logic [HDR_BITS-1:0] UNAS_CARE = ~HDR_BITS'(4'he);

  logic [POS_W-1:0]    pos_cnt, cur_pos;
  logic [HDR_BITS-1:0] hdr_q, fixed_hdr;
  hec_pol_e            pol_q;
  logic                hec_now, syn_err, syn_single, fix_en, drop;
  logic [CW_BITS-1:0]  flip, mask, mask_q;
  logic                drop_q, idle_q, unas_q;
  beat_t               head, tail;
  logic [7:0]          mbyte;
  logic                tail_eop;

  assign cur_pos = in_sop_i ? '0 : pos_cnt;
  assign hec_now = in_valid_i && (cur_pos == HEC_POS);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pos_cnt <= '0;
      hdr_q   <= '0;
      pol_q   <= POL_PASS;
    end else if (in_valid_i) begin
      pos_cnt <= cur_pos + 1'b1;
      if (in_sop_i) pol_q <= hec_pol_e'(mode_i);
      for (int b = 0; b < HDR_BYTES; b++)
        if (cur_pos == POS_W'(b)) hdr_q[8*(HDR_BYTES-1-b) +: 8] <= in_data_i;
    end

  hec_syndrome #(.COSET(COSET)) u_syn (
    .hdr_i   (hdr_q),
    .hec_i   (in_data_i),
    .flip_o  (flip),
    .err_o   (syn_err),
    .single_o(syn_single)
  );

  always_comb begin
    fix_en    = pol_q[0] && syn_single;
    drop      = (pol_q == POL_DROP    && syn_err) ||
                (pol_q == POL_FIXDROP && syn_err && !syn_single);
    mask      = fix_en ? flip : '0;
    fixed_hdr = hdr_q ^ mask[CW_BITS-1:8];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mask_q <= '0;
      drop_q <= 1'b0;
      idle_q <= 1'b0;
      unas_q <= 1'b0;
    end else if (hec_now) begin
      mask_q <= mask;
      drop_q <= drop;
      idle_q <= (fixed_hdr == IDLE_HDR);
      unas_q <= ((fixed_hdr & UNAS_CARE) == '0);
    end

  assign head = '{vld: in_valid_i, pos: cur_pos, dat: in_data_i};

  hec_delay #(.DEPTH(ALIGN)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (head),
    .out_o (tail)
  );

  always_comb begin
    mbyte = '0;
    for (int b = 0; b <= HDR_BYTES; b++)
      if (tail.pos == POS_W'(b)) mbyte = mask_q[8*(HDR_BYTES-b) +: 8];
    tail_eop = tail.vld && (tail.pos == LAST_POS);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_sop_o    <= 1'b0;
      out_eop_o    <= 1'b0;
      out_data_o   <= '0;
      discard_o    <= 1'b0;
      idle_o       <= 1'b0;
      unassigned_o <= 1'b0;
    end else begin
      out_valid_o  <= tail.vld;
      out_sop_o    <= tail.vld && (tail.pos == '0);
      out_eop_o    <= tail_eop;
      out_data_o   <= tail.dat ^ (tail.vld ? mbyte : 8'h00);
      discard_o    <= tail_eop && drop_q;
      idle_o       <= tail_eop && idle_q;
      unassigned_o <= tail_eop && unas_q;
    end
endmodule

// File: rtl/hec_checker_sva.sv
module hec_checker_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_sop_i,
  input logic out_valid_o,
  input logic out_sop_o,
  input logic out_eop_o,
  input logic discard_o,
  input logic idle_o,
  input logic unassigned_o
);
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i, 6)); // R10
  AST_SOP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o == $past(in_valid_i && in_sop_i, 6)); // R10
  AST_EOP_HAS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eop_o |-> out_valid_o); // R10
  AST_MARKS_AT_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (discard_o || idle_o || unassigned_o) |-> out_eop_o); // R11
  AST_IDLE_NOT_UNAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(idle_o && unassigned_o)); // R8
endmodule

bind hec_checker hec_checker_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_sop_i    (in_sop_i),
  .out_valid_o (out_valid_o),
  .out_sop_o   (out_sop_o),
  .out_eop_o   (out_eop_o),
  .discard_o   (discard_o),
  .idle_o      (idle_o),
  .unassigned_o(unassigned_o)
);

// File: tb/sim_hec_checker.sv
`timescale 1ns/1ps
module sim_hec_checker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid, out_sop, out_eop, discard, idle, unas;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0, cyc = 0, cell_cnt = 0, oi = 0;
  int sop_cyc = 0, osop_cyc = 0;
  logic [7:0] ob [53];
  logic [7:0] pay [48];
  logic f_drop, f_idle, f_unas;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  hec_checker u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .in_valid_i(in_valid),
    .in_sop_i(in_sop), .in_data_i(in_data), .out_valid_o(out_valid),
    .out_sop_o(out_sop), .out_eop_o(out_eop), .out_data_o(out_data),
    .discard_o(discard), .idle_o(idle), .unassigned_o(unas)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && (discard || idle || unas) && !out_eop)
      chk(1'b0, "R11", "mark without end marker", {discard, idle, unas}, 3'b000);
    if (out_valid) begin
      if (out_sop) begin oi = 0; osop_cyc = cyc; end
      if (oi < 53) ob[oi] = out_data;
      oi++;
      if (out_eop) begin
        f_drop = discard; f_idle = idle; f_unas = unas;
        cell_cnt++;
      end
    end
  end

  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int by = 3; by >= 0; by--)
      for (int bt = 7; bt >= 0; bt--) begin
        logic x = c[7] ^ h[8*by+bt];
        c = {c[6:0], 1'b0} ^ (x ? 8'h07 : 8'h00);
      end
    return c ^ 8'h55;
  endfunction

  task automatic send_cell(input logic [1:0] md, input logic [31:0] h, input logic [7:0] hc,
                           input bit gaps, input bit mchg, input string rq);
    logic [39:0] cw, ecw;
    bit err, one, edrop;
    int target;
    cw = {h, hc};
    ecw = cw;
    err = (ref_hec(h) != hc);
    one = 1'b0;
    if (err)
      for (int k = 0; k < 40; k++) begin
        logic [39:0] t = cw ^ (40'd1 << k);
        if (!one && ref_hec(t[39:8]) == t[7:0]) begin one = 1'b1; if (md[0]) ecw = t; end
      end
    edrop = (md == 2'b10 && err) || (md == 2'b11 && err && !one);
    for (int i = 0; i < 48; i++) pay[i] = 8'($urandom);
    target = cell_cnt + 1;
    for (int i = 0; i < 53; i++) begin
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_data  = (i < 5) ? cw[39-8*i -: 8] : pay[i-5];
      mode     = (i == 0 || !mchg) ? md : ~md;
      if (i == 0) sop_cyc = cyc;
      @(negedge clk);
      if (gaps && i >= 4 && i < 52 && ($urandom % 3 == 0)) begin
        in_valid = 1'b0; in_sop = 1'b0;
        @(negedge clk);
      end
    end
    in_valid = 1'b0; in_sop = 1'b0;
    while (cell_cnt != target) @(negedge clk);
    chk({ob[0], ob[1], ob[2], ob[3], ob[4]} == ecw, rq, "header bytes",
        {ob[0], ob[1], ob[2], ob[3], ob[4]}, ecw);
    begin
      bit pok = 1'b1;
      for (int i = 0; i < 48; i++) if (ob[i+5] !== pay[i]) pok = 1'b0;
      chk(pok, "R10", "payload passthrough", 64'(pok), 64'd1);
    end
    chk(osop_cyc - sop_cyc == 6, "R10", "latency", 64'(osop_cyc - sop_cyc), 64'd6);
    chk(f_drop == edrop, rq, "discard mark", 64'(f_drop), 64'(edrop));
    chk({f_idle, f_unas} == {ecw[39:8] == 32'h1, (ecw[39:8] & 32'hFFFF_FFF1) == 32'h0},
        rq, "idle/unassigned marks", {f_idle, f_unas},
        {ecw[39:8] == 32'h1, (ecw[39:8] & 32'hFFFF_FFF1) == 32'h0});
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] h;
    void'($urandom(32'd1234));
    repeat (8) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({out_valid, out_sop, out_eop, discard, idle, unas} == 6'b0, "R10", "reset state",
        {out_valid, out_sop, out_eop, discard, idle, unas}, 6'b0);

    h = 32'h1234_5670;
    for (int m = 0; m < 4; m++) send_cell(2'(m), h, ref_hec(h), 1'b0, 1'b0, "R1");
    send_cell(2'b00, h, ref_hec(h) ^ 8'h11, 1'b0, 1'b0, "R2");
    send_cell(2'b01, h ^ 32'h0010_0000, ref_hec(h), 1'b0, 1'b0, "R3");
    send_cell(2'b01, h, ref_hec(h) ^ 8'h20, 1'b0, 1'b0, "R3");
    send_cell(2'b01, h ^ 32'h0000_0300, ref_hec(h), 1'b0, 1'b0, "R4");
    send_cell(2'b10, h ^ 32'h8000_0000, ref_hec(h), 1'b0, 1'b0, "R5");
    send_cell(2'b11, h ^ 32'h0000_0004, ref_hec(h), 1'b0, 1'b0, "R6");
    send_cell(2'b11, h ^ 32'h0401_0000, ref_hec(h), 1'b0, 1'b0, "R6");
    send_cell(2'b00, 32'h1, ref_hec(32'h1), 1'b0, 1'b0, "R7");
    send_cell(2'b11, 32'h1 ^ 32'h0010_0000, ref_hec(32'h1), 1'b0, 1'b0, "R7");
    send_cell(2'b10, 32'h0000_000A, ref_hec(32'h0000_000A), 1'b0, 1'b0, "R8");
    send_cell(2'b11, 32'h0000_0006, ref_hec(32'h0000_0006), 1'b1, 1'b0, "R8");
    send_cell(2'b00, h ^ 32'h0000_0300, ref_hec(h), 1'b0, 1'b1, "R9");
    send_cell(2'b11, h ^ 32'h0000_0300, ref_hec(h), 1'b0, 1'b1, "R9");
    send_cell(2'b10, h, ref_hec(h), 1'b1, 1'b0, "R10");

    for (int n = 0; n < 60; n++) begin
      logic [1:0] md = 2'($urandom);
      logic [39:0] cw;
      int ne = $urandom % 3;
      string rq;
      h = ($urandom % 4 == 0) ? (32'($urandom) & 32'h0000_000F) : 32'($urandom);
      cw = {h, ref_hec(h)};
      for (int e = 0; e < ne; e++) cw = cw ^ (40'd1 << ($urandom % 40));
      rq = (md == 2'b00) ? "R2" : (md == 2'b01) ? "R3" : (md == 2'b10) ? "R5" : "R6";
      send_cell(md, cw[39:8], cw[7:0], 1'($urandom), 1'($urandom), rq);
    end
    finish_run();
  end
endmodule